// File: doc/BRIEF.md
# DMA Data Width Adapter

This block sits in the data path of a DMA channel. It takes one source single of 1, 2 or 4 bytes and turns it into one destination single of 1, 2 or 4 bytes. The 32-bit input word holds the source single in its low bytes. The 32-bit output word holds the destination single in its low bytes, and every bit above the destination width is zero. When the two widths match, the data goes through unchanged.

When the widths differ, a single mode bit selects the conversion. For widening, mode 0 pads the upper bytes with zeros and mode 1 sign-extends the source's top bit. For narrowing, mode 0 keeps the least significant destination-width bytes and mode 1 keeps the most significant destination-width bytes of the source single. A reserved width code on either side gives a zero output and raises a configuration error flag.

By default the result is registered: the output shows the conversion of the inputs sampled at the previous rising clock edge. A parameter selects a purely combinational variant instead.

Top module: `dwa_top`

## Requirements
- R1: When the source and destination width codes are equal and legal, the output equals the source data with all bits above the width cleared, for either value of pad_mode.
- R2: When the destination is wider than the source and pad_mode is 0, the output holds the source bytes in its low lanes and zeros in every byte above them.
- R3: When the destination is wider than the source and pad_mode is 1, the source bytes stay in the low lanes and every bit between the source width and the destination width is a copy of source bit 8*source_bytes-1.
- R4: When the destination is narrower than the source and pad_mode is 0, the output holds the lowest destination-width bytes of the source data.
- R5: When the destination is narrower than the source and pad_mode is 1, the output holds source bytes (source_bytes - destination_bytes) up to (source_bytes - 1), moved down into the low lanes.
- R6: Width codes are 2 bits: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. For any legal pair, output bits at and above 8*destination_bytes are zero.
- R7: Width code 3 on src_wcode or dst_wcode forces dst_data to zero and cfg_err to 1. With two legal codes, cfg_err is 0.
- R8: With the default registered build, dst_data and cfg_err show the conversion of the inputs sampled at the previous rising edge of clk. While rst_n is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_data | input | 32 | Source single, right-justified |
| src_wcode | input | 2 | Source width code (0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: reserved) |
| dst_wcode | input | 2 | Destination width code, same encoding as src_wcode |
| pad_mode | input | 1 | 0: zero-pad or keep low bytes; 1: sign-extend or keep high bytes |
| dst_data | output | 32 | Destination single, right-justified, zero above its width |
| cfg_err | output | 1 | Set when either width code is reserved |

## Verification
The case that is hardest to reach from the ports is a sign extension in which the source's top bit sits exactly at a lane edge while the neighbouring bytes of the input word hold non-zero data. Only with that stimulus can a wrong fill value be told apart from stale upper bytes. The stimulus sweeps every pair of width codes with both mode values over fixed words chosen so that bit 7, bit 15 and bit 31 each appear set and clear next to busy neighbour bytes. Random words follow, and then a reset in the middle of the run.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

  typedef enum logic [1:0] {
    WC_B1  = 2'd0,
    WC_B2  = 2'd1,
    WC_B4  = 2'd2,
    WC_RSV = 2'd3
  } wcode_e;

  typedef logic [2:0] lanes_t;

  // Number of byte lanes a width code stands for; 0 marks the reserved code.
  function automatic lanes_t code_lanes(input logic [1:0] code);
    case (wcode_e'(code))
      WC_B1:   return 3'd1;
      WC_B2:   return 3'd2;
      WC_B4:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dwa_decode.sv
module dwa_decode
  import dwa_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [1:0] src_code,
  input  logic [1:0] dst_code,
  output lanes_t     src_lanes,
  output lanes_t     dst_lanes,
  output logic       cfg_bad,
  output logic       grow,
  output logic       shrink
);

  logic src_ok;
  logic dst_ok;

  function automatic logic lanes_fit(input lanes_t n);
    return (n != 3'd0) && (int'(n) <= LANES);
  endfunction

  always_comb begin
    src_lanes = code_lanes(src_code);
    dst_lanes = code_lanes(dst_code);
    src_ok    = lanes_fit(src_lanes);
    dst_ok    = lanes_fit(dst_lanes);
    cfg_bad   = !(src_ok && dst_ok);
    grow      = !cfg_bad && (dst_lanes > src_lanes);
    shrink    = !cfg_bad && (dst_lanes < src_lanes);
  end

endmodule

// File: rtl/dwa_widen.sv
module dwa_widen
  import dwa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  lanes_t            src_lanes,
  input  lanes_t            dst_lanes,
  input  logic              sign_mode,
  output logic [DATA_W-1:0] dout,
  output logic              fill_bit
);

  localparam int LANES = DATA_W / 8;

  // Top bit of the source single, found by lane count.
  function automatic logic src_msb(input logic [DATA_W-1:0] d, input lanes_t n);
    logic r;
    r = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (k + 1 == int'(n)) r = d[8*k+7];
    end
    return r;
  endfunction

  assign fill_bit = sign_mode & src_msb(din, src_lanes);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (g < int'(src_lanes)) begin
        dout[8*g +: 8] = din[8*g +: 8];
      end else if (g < int'(dst_lanes)) begin
        dout[8*g +: 8] = {8{fill_bit}};
      end else begin
        dout[8*g +: 8] = 8'h00;
      end
    end
  end

endmodule

// File: rtl/dwa_narrow.sv
module dwa_narrow
  import dwa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  lanes_t            src_lanes,
  input  lanes_t            dst_lanes,
  input  logic              keep_high,
  output logic [DATA_W-1:0] dout
);

  localparam int LANES = DATA_W / 8;

  int unsigned lane_skip;

  function automatic logic [7:0] lane_at(input logic [DATA_W-1:0] d, input int unsigned idx);
    logic [7:0] r;
    r = 8'h00;
    for (int k = 0; k < LANES; k++) begin
      if (k == int'(idx)) r = d[8*k +: 8];
    end
    return r;
  endfunction

  always_comb begin
    lane_skip = 0;
    if (keep_high && (src_lanes > dst_lanes)) begin
      lane_skip = int'(src_lanes) - int'(dst_lanes);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (g < int'(dst_lanes)) begin
        dout[8*g +: 8] = lane_at(din, lane_skip + g);
      end else begin
        dout[8*g +: 8] = 8'h00;
      end
    end
  end

endmodule

// File: rtl/dwa_top.sv
module dwa_top
  import dwa_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_data,
  input  logic [1:0]        src_wcode,
  input  logic [1:0]        dst_wcode,
  input  logic              pad_mode,
  output logic [DATA_W-1:0] dst_data,
  output logic              cfg_err
);

  localparam int LANES = DATA_W / 8;

  lanes_t            src_lanes;
  lanes_t            dst_lanes;
  logic              cfg_bad;
  logic              grow;
  logic              shrink;
  logic              fill_bit;
  logic [DATA_W-1:0] widen_out;
  logic [DATA_W-1:0] narrow_out;
  logic [DATA_W-1:0] next_data;

  dwa_decode #(.LANES(LANES)) u_decode (
    .src_code  (src_wcode),
    .dst_code  (dst_wcode),
    .src_lanes (src_lanes),
    .dst_lanes (dst_lanes),
    .cfg_bad   (cfg_bad),
    .grow      (grow),
    .shrink    (shrink)
  );

  // Also serves equal widths: no fill lanes exist then, so pad_mode has no effect.
  dwa_widen #(.DATA_W(DATA_W)) u_widen (
    .din       (src_data),
    .src_lanes (src_lanes),
    .dst_lanes (dst_lanes),
    .sign_mode (pad_mode),
    .dout      (widen_out),
    .fill_bit  (fill_bit)
  );

  dwa_narrow #(.DATA_W(DATA_W)) u_narrow (
    .din       (src_data),
    .src_lanes (src_lanes),
    .dst_lanes (dst_lanes),
    .keep_high (pad_mode),
    .dout      (narrow_out)
  );

  always_comb begin
    if (cfg_bad)     next_data = '0;
    else if (shrink) next_data = narrow_out;
    else             next_data = widen_out;
  end

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dst_data <= '0;
        cfg_err  <= 1'b0;
      end else begin
        dst_data <= next_data;
        cfg_err  <= cfg_bad;
      end
    end
  end else begin : g_comb
    assign dst_data = next_data;
    assign cfg_err  = cfg_bad;
  end

endmodule

// File: rtl/dwa_top_chk.sv
module dwa_top_chk #(
  parameter int DATA_W     = 32,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] src_data,
  input logic [1:0]        src_wcode,
  input logic [1:0]        dst_wcode,
  input logic              pad_mode,
  input logic [DATA_W-1:0] dst_data,
  input logic              cfg_err,
  input logic              grow,
  input logic              fill_bit
);

  logic primed;

  function automatic logic [DATA_W-1:0] code_mask(input logic [1:0] c);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if ((c != 2'd3) && (b < (8 << c))) m[b] = 1'b1;
    end
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (dst_data == '0));

  if (REGISTERED) begin : g_seq
    // R7
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && ($past(src_wcode) == 2'd3 || $past(dst_wcode) == 2'd3)) |-> cfg_err);

    // R1
    same_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(src_wcode == dst_wcode && src_wcode != 2'd3))
        |-> (dst_data == ($past(src_data) & code_mask($past(dst_wcode)))));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !cfg_err) |-> ((dst_data & ~code_mask($past(dst_wcode))) == '0));

    // R2
    zero_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(grow && !pad_mode)) |-> ((dst_data & ~code_mask($past(src_wcode))) == '0));

    // R3
    sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(grow && fill_bit))
        |-> ((dst_data & code_mask($past(dst_wcode)) & ~code_mask($past(src_wcode)))
             == (code_mask($past(dst_wcode)) & ~code_mask($past(src_wcode)))));
  end

endmodule

bind dwa_top dwa_top_chk #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_data  (src_data),
  .src_wcode (src_wcode),
  .dst_wcode (dst_wcode),
  .pad_mode  (pad_mode),
  .dst_data  (dst_data),
  .cfg_err   (cfg_err),
  .grow      (grow),
  .fill_bit  (fill_bit)
);

// File: tb/dwa_top_bench.sv
module dwa_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_data = '0;
  logic [1:0]  src_wcode = '0;
  logic [1:0]  dst_wcode = '0;
  logic        pad_mode = 1'b0;
  logic [31:0] dst_data;
  logic        cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Expected results queued one cycle ahead of the registered output.
  logic [31:0] exp_q[$];
  bit          err_q[$];
  string       tag_q[$];
  int          dw_q[$];

  always #4 clk = ~clk;

  dwa_top u_dwa_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_data  (src_data),
    .src_wcode (src_wcode),
    .dst_wcode (dst_wcode),
    .pad_mode  (pad_mode),
    .dst_data  (dst_data),
    .cfg_err   (cfg_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: work in byte counts with wide integers.
  function automatic void model(input logic [31:0] s, input int sc, input int dc, input bit m,
                                output logic [31:0] o, output bit e, output string tag);
    longint unsigned v, smask, dmask;
    int sb, db;
    if (sc == 3 || dc == 3) begin
      o = 32'h0; e = 1'b1; tag = "R7"; return;
    end
    e = 1'b0;
    sb = 1 << sc;
    db = 1 << dc;
    smask = (64'd1 << (8 * sb)) - 1;
    dmask = (64'd1 << (8 * db)) - 1;
    v = longint'(s) & smask;
    if (db == sb) begin
      tag = "R1";
    end else if (db > sb) begin
      tag = m ? "R3" : "R2";
      if (m && ((v >> (8 * sb - 1)) & 1) == 1) v = v | (dmask & ~smask);
    end else begin
      tag = m ? "R5" : "R4";
      if (m) v = v >> (8 * (sb - db));
      v = v & dmask;
    end
    o = v[31:0];
  endfunction

  task automatic drive(input logic [31:0] s, input int sc, input int dc, input bit m);
    logic [31:0] o;
    bit e;
    string tag;
    @(negedge clk);
    if (exp_q.size() != 0) begin
      logic [31:0] eo = exp_q.pop_front();
      bit          ee = err_q.pop_front();
      string       et = tag_q.pop_front();
      int          ed = dw_q.pop_front();
      check(et, dst_data, eo);
      check("R7", {31'h0, cfg_err}, {31'h0, ee});
      if (ed != 3) check("R6", dst_data & ~((32'h1 << (8 << ed)) - 1 | ((ed == 2) ? 32'hFFFF_FFFF : 32'h0)), 32'h0);
    end
    src_data  = s;
    src_wcode = 2'(sc);
    dst_wcode = 2'(dc);
    pad_mode  = m;
    model(s, sc, dc, m, o, e, tag);
    exp_q.push_back(o);
    err_q.push_back(e);
    tag_q.push_back(tag);
    dw_q.push_back(dc);
  endtask

  initial begin
    logic [31:0] pats[8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8081_8283,
                             32'h7F7F_7F7F, 32'h0000_FF80, 32'hA5C3_E17E, 32'h0000_8000};
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", dst_data, 32'h0);
    check("R8", {31'h0, cfg_err}, 32'h0);
    rst_n = 1'b1;
    for (int p = 0; p < 8; p++)
      for (int sc = 0; sc < 4; sc++)
        for (int dc = 0; dc < 4; dc++)
          for (int m = 0; m < 2; m++)
            drive(pats[p], sc, dc, m[0]);
    for (int r = 0; r < 300; r++)
      drive($urandom, int'($urandom_range(3, 0)), int'($urandom_range(3, 0)), 1'($urandom));
    drive(32'h0, 0, 0, 1'b0);
    // R8: reset in mid-run clears both outputs
    drive(32'hDEAD_BEEF, 2, 2, 1'b0);
    @(negedge clk);
    check("R8", dst_data, 32'hDEAD_BEEF);
    rst_n = 1'b0;
    exp_q.delete(); err_q.delete(); tag_q.delete(); dw_q.delete();
    @(posedge clk);
    @(negedge clk);
    check("R8", dst_data, 32'h0);
    check("R8", {31'h0, cfg_err}, 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule